// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank with Snapshot Readout

This block keeps the frame and octet statistics of a 10G Ethernet MAC. The receive and transmit paths deliver one-cycle event pulses on a fifteen-bit vector. The two octet events also carry the byte count of the frame that just ended. Each event feeds its own 40-bit live counter.

A host never reads the live counters directly. It first writes a snapshot command, which copies every live counter into a shadow copy at one clock edge. It then reads the shadow copies through 16-bit register words, so all the values it collects belong to the same instant. Wraparound of any live counter is recorded in a 64-bit rollover vector that is cleared when read. A clear command resets the whole bank.

Top module: `mac_stat_bank`

## Requirements
- R1: Counter slot s occupies register addresses 4*s to 4*s+3 (address bits 7:2 give the slot, bits 1:0 give the word). Word 0 returns shadow bits 15:0. Word 1 returns bits 31:16. Word 2 returns bits 39:32 in its low byte, with its upper byte zero.
- R2: Event bit i of `cnt_ev` maps to a fixed slot. Bits 0 to 9 are receive events and map to slots 1, 4, 5, 6, 8, 10, 16, 17, 18 and 25. Bits 10 to 14 are transmit events and map to slots 33, 38, 40, 42 and 43. Bit 0 (receive octets) adds `rx_bytes` per event and bit 10 (transmit octets) adds `tx_bytes` per event. Every other counter adds one per event.
- R3: A write to address 0x100 with data bit 0 set copies every live counter into its shadow at that clock edge. Counter register reads return the shadow values.
- R4: Shadow values hold between snapshots, and events change none of them. An event that arrives in the same cycle as a snapshot reaches the live counter only, so the shadow takes the value from before that event.
- R5: A write to address 0x100 with data bit 1 set zeroes all live counters, all shadows and all rollover flags. It takes priority over a snapshot and over events in the same cycle.
- R6: When a live counter wraps from its top value past zero, the rollover flag of its slot is set. The flags read at addresses 0x104 to 0x107. Word k holds slots 16k to 16k+15, with bit (slot mod 16) for each slot.
- R7: Reading a rollover word returns its current flags and clears them at that edge. If a wrap occurs in the same cycle as the read, that flag stays set.
- R8: The following read as zero: slots that hold no counter, word 3 of every slot, the control address and all other unmapped addresses. The rollover flags of unused slots are never set.
- R9: After reset, every counter, shadow and rollover flag reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_ev | input | 15 | One-cycle event pulses, one bit per counter |
| rx_bytes | input | BYTE_W | Byte count added with a receive-octet event |
| tx_bytes | input | BYTE_W | Byte count added with a transmit-octet event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears rollover flags) |
| reg_addr | input | 9 | Register word address |
| reg_wdata | input | 16 | Write data (bit 0 snapshot, bit 1 clear) |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |

## Verification
Two pairs of operations can fall on the same edge. The first pair is a snapshot and a counter event. The bench issues them together and then reads every counter, expecting each shadow to hold the count from before that event. The second pair is a rollover-word read and a wrap of the same counter. The bench pushes the receive-octet counter to four below its limit, then issues the read and the wrapping event in one cycle. It expects the read to return the flag that was already set, and the next read to still show that flag.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;
  localparam int NUM_CNT  = 15;
  localparam int NUM_SLOT = 64;
  localparam int WORD_W   = 16;
  localparam int REG_AW   = 9;
  localparam logic [REG_AW-1:0] CTRL_ADDR = 9'h100;
  localparam logic [REG_AW-1:0] ROLL_BASE = 9'h104;

  // fixed slot position of each event counter
  function automatic int unsigned cnt_slot(input int unsigned idx);
    case (idx)
      0:  return 1;
      1:  return 4;
      2:  return 5;
      3:  return 6;
      4:  return 8;
      5:  return 10;
      6:  return 16;
      7:  return 17;
      8:  return 18;
      9:  return 25;
      10: return 33;
      11: return 38;
      12: return 40;
      13: return 42;
      default: return 43;
    endcase
  endfunction

  function automatic logic cnt_is_octet(input int unsigned idx);
    return (idx == 0) || (idx == 10);
  endfunction

  function automatic logic cnt_is_rx(input int unsigned idx);
    return idx < 10;
  endfunction

  function automatic logic [NUM_SLOT-1:0] used_slots();
    logic [NUM_SLOT-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) m[cnt_slot(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mac_stat_counter.sv
module mac_stat_counter #(
  parameter int CNT_W = 40,
  parameter int INC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             snap_i,
  input  logic             inc_en_i,
  input  logic [INC_W-1:0] inc_val_i,
  output logic [CNT_W-1:0] live_o,
  output logic [CNT_W-1:0] shadow_o,
  output logic             wrap_o
);
  localparam int SUM_W = CNT_W + 1;

  // carry-extended sum: the top bit marks a wrap
  function automatic logic [SUM_W-1:0] add_inc(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    return {1'b0, a} + SUM_W'(b);
  endfunction

  logic [CNT_W-1:0] live_q, shadow_q;
  logic [SUM_W-1:0] sum;

  assign sum    = add_inc(live_q, inc_val_i);
  assign wrap_o = inc_en_i & ~clr_i & sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else if (clr_i) begin
      live_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (snap_i)   shadow_q <= live_q;
      if (inc_en_i) live_q   <= sum[CNT_W-1:0];
    end
  end

  assign live_o   = live_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/mac_stat_regmux.sv
module mac_stat_regmux
  import mac_stat_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input  logic [REG_AW-1:0]              reg_addr_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]  shadow_i,
  input  logic [NUM_SLOT-1:0]            roll_i,
  output logic [WORD_W-1:0]              rdata_o
);
  localparam int EXT_W = 3 * WORD_W;

  function automatic logic [WORD_W-1:0] word_of(input logic [CNT_W-1:0] v,
                                                input logic [1:0] w);
    logic [EXT_W-1:0] ext;
    ext = EXT_W'(v);
    case (w)
      2'd0:    return ext[WORD_W-1:0];
      2'd1:    return ext[2*WORD_W-1:WORD_W];
      2'd2:    return ext[3*WORD_W-1:2*WORD_W];
      default: return '0;
    endcase
  endfunction

  always_comb begin
    rdata_o = '0;
    if (!reg_addr_i[REG_AW-1]) begin
      for (int i = 0; i < NUM_CNT; i++)
        if (reg_addr_i[7:2] == 6'(cnt_slot(i)))
          rdata_o = word_of(shadow_i[i], reg_addr_i[1:0]);
    end else if (reg_addr_i[REG_AW-1:2] == ROLL_BASE[REG_AW-1:2]) begin
      rdata_o = roll_i[reg_addr_i[1:0]*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
  import mac_stat_pkg::*;
#(
  parameter int CNT_W  = 40,
  parameter int BYTE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] cnt_ev,
  input  logic [BYTE_W-1:0]  rx_bytes,
  input  logic [BYTE_W-1:0]  tx_bytes,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata
);
  // named internal events
  logic                          ctrl_hit, snap_cmd, clr_cmd, roll_rd_hit;
  logic [NUM_SLOT-1:0]           roll_rd_mask, wrap_vec, roll_q;
  logic [NUM_CNT-1:0]            cnt_wrap;
  logic [NUM_CNT-1:0][CNT_W-1:0] live_all, shadow_all;
  logic                          wdata_unused;

  assign ctrl_hit     = reg_wr && (reg_addr == CTRL_ADDR);
  assign snap_cmd     = ctrl_hit && reg_wdata[0];
  assign clr_cmd      = ctrl_hit && reg_wdata[1];
  assign roll_rd_hit  = reg_rd && (reg_addr[REG_AW-1:2] == ROLL_BASE[REG_AW-1:2]);
  assign wdata_unused = ^reg_wdata[WORD_W-1:2];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [BYTE_W-1:0] inc_val;
    if (cnt_is_octet(g)) begin : g_oct
      assign inc_val = cnt_is_rx(g) ? rx_bytes : tx_bytes;
    end else begin : g_frm
      assign inc_val = BYTE_W'(1);
    end
    mac_stat_counter #(.CNT_W(CNT_W), .INC_W(BYTE_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr_cmd),
      .snap_i    (snap_cmd),
      .inc_en_i  (cnt_ev[g]),
      .inc_val_i (inc_val),
      .live_o    (live_all[g]),
      .shadow_o  (shadow_all[g]),
      .wrap_o    (cnt_wrap[g])
    );
  end

  always_comb begin
    wrap_vec = '0;
    for (int i = 0; i < NUM_CNT; i++) wrap_vec[6'(cnt_slot(i))] = cnt_wrap[i];
  end

  always_comb begin
    roll_rd_mask = '0;
    if (roll_rd_hit) roll_rd_mask[reg_addr[1:0]*WORD_W +: WORD_W] = '1;
  end

  // a new wrap outranks the clear-on-read of the same flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       roll_q <= '0;
    else if (clr_cmd) roll_q <= '0;
    else              roll_q <= (roll_q & ~roll_rd_mask) | wrap_vec;
  end

  mac_stat_regmux #(.CNT_W(CNT_W)) u_mux (
    .reg_addr_i (reg_addr),
    .shadow_i   (shadow_all),
    .roll_i     (roll_q),
    .rdata_o    (reg_rdata)
  );
endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk
  import mac_stat_pkg::*;
#(
  parameter int CNT_W = 40
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          snap_cmd,
  input logic                          clr_cmd,
  input logic [NUM_SLOT-1:0]           wrap_vec,
  input logic [NUM_SLOT-1:0]           roll_rd_mask,
  input logic [NUM_SLOT-1:0]           roll_q,
  input logic [NUM_CNT-1:0][CNT_W-1:0] live_all,
  input logic [NUM_CNT-1:0][CNT_W-1:0] shadow_all
);
  localparam logic [NUM_SLOT-1:0] USED = used_slots();

  a_r3_snap_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_cmd && !clr_cmd) |=> (shadow_all == $past(live_all)));

  a_r4_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_cmd && !clr_cmd) |=> $stable(shadow_all));

  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (live_all == '0 && shadow_all == '0 && roll_q == '0));

  a_r6_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_vec != '0) |=> ((roll_q & $past(wrap_vec)) == $past(wrap_vec)));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_rd_mask != '0 && !clr_cmd) |=>
      ((roll_q & $past(roll_rd_mask)) == ($past(wrap_vec) & $past(roll_rd_mask))));

  a_r8_unused_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_q & ~USED) == '0);
endmodule

bind mac_stat_bank mac_stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .snap_cmd     (snap_cmd),
  .clr_cmd      (clr_cmd),
  .wrap_vec     (wrap_vec),
  .roll_rd_mask (roll_rd_mask),
  .roll_q       (roll_q),
  .live_all     (live_all),
  .shadow_all   (shadow_all)
);

// File: tb/mac_stat_bank_tb.sv
module mac_stat_bank_tb;
  localparam int BW = 38;
  localparam int SLOT_OF [15] = '{1, 4, 5, 6, 8, 10, 16, 17, 18, 25, 33, 38, 40, 42, 43};
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};

  typedef struct packed {
    logic [14:0]   ev;
    logic [BW-1:0] rb;
    logic [BW-1:0] tb;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{15'h7FFF, 38'd64,   38'd1518},
    '{15'h0001, 38'd9000, 38'd0},
    '{15'h5555, 38'd1500, 38'd77},
    '{15'h2AAA, 38'd1,    38'd9018},
    '{15'h0400, 38'd5,    38'd12345},
    '{15'h0000, 38'd999,  38'd999}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [14:0] cnt_ev = '0;
  logic [BW-1:0] rx_bytes = '0, tx_bytes = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [39:0] m_live [15];
  logic [39:0] m_shad [15];
  logic [63:0] m_roll;
  logic [15:0] got;

  always #2 clk = ~clk;

  mac_stat_bank #(.CNT_W(40), .BYTE_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_ev(cnt_ev), .rx_bytes(rx_bytes), .tx_bytes(tx_bytes),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] exp_rd(input logic [8:0] a);
    logic [15:0] r;
    r = '0;
    if (a < 9'd256) begin
      for (int i = 0; i < 15; i++)
        if (SLOT_OF[i] == int'(a >> 2)) begin
          if (a[1:0] == 2'd0) r = m_shad[i][15:0];
          else if (a[1:0] == 2'd1) r = m_shad[i][31:16];
          else if (a[1:0] == 2'd2) r = {8'h00, m_shad[i][39:32]};
        end
    end else if (a >= 9'h104 && a <= 9'h107) begin
      r = m_roll[(a - 9'h104) * 16 +: 16];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns later, update the model, release
  task automatic cyc(input logic [14:0] ev, input logic [BW-1:0] rb, input logic [BW-1:0] tb,
                     input logic snap, input logic clr, input logic rd,
                     input logic [8:0] addr, input string tag);
    logic [40:0] s;
    cnt_ev = ev; rx_bytes = rb; tx_bytes = tb;
    reg_wr = snap | clr; reg_wdata = {14'd0, clr, snap};
    reg_rd = rd; reg_addr = (snap | clr) ? 9'h100 : addr;
    #1;
    got = reg_rdata;
    if (rd) chk(tag, got, exp_rd(addr));
    if (clr) begin
      for (int i = 0; i < 15; i++) begin m_live[i] = '0; m_shad[i] = '0; end
      m_roll = '0;
    end else begin
      if (rd && addr >= 9'h104 && addr <= 9'h107) m_roll[(addr - 9'h104) * 16 +: 16] = '0;
      if (snap) for (int i = 0; i < 15; i++) m_shad[i] = m_live[i];
      for (int i = 0; i < 15; i++)
        if (ev[i]) begin
          if (i == 0) s = {1'b0, m_live[i]} + 41'(rb);
          else if (i == 10) s = {1'b0, m_live[i]} + 41'(tb);
          else s = {1'b0, m_live[i]} + 41'd1;
          if (s[40]) m_roll[SLOT_OF[i]] = 1'b1;
          m_live[i] = s[39:0];
        end
    end
    @(negedge clk);
    cnt_ev = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0; reg_addr = '0;
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    cyc('0, '0, '0, 1'b0, 1'b0, 1'b1, a, tag);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 15; i++)
      for (int w = 0; w < 4; w++) rd(9'(SLOT_OF[i] * 4 + w), tag);
  endtask

  initial begin
    for (int i = 0; i < 15; i++) begin m_live[i] = '0; m_shad[i] = '0; end
    m_roll = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    read_all("R9 reset counters");
    for (int k = 0; k < 4; k++) rd(9'(9'h104 + k), "R9 reset rollover");

    // R2 table of event patterns, then R3 snapshot and R1 word split
    for (int v = 0; v < 6; v++) cyc(VECS[v].ev, VECS[v].rb, VECS[v].tb, 1'b0, 1'b0, 1'b0, '0, "");
    read_all("R4 no change before snap");
    cyc('0, '0, '0, 1'b1, 1'b0, 1'b0, '0, "");
    read_all("R2 R3 counts after snap");

    // R8 unused slots, pad word, control and unmapped addresses
    rd(9'h008 + 9'd3, "R8 pad word");
    rd(9'h008, "R8 unused slot 2");
    rd(9'h0FC, "R8 unused slot 63");
    rd(9'h100, "R8 control reads zero");
    rd(9'h1F0, "R8 unmapped");

    // R4 event in the snapshot cycle stays out of that shadow
    cyc(15'h7FFF, 38'd10, 38'd20, 1'b1, 1'b0, 1'b0, '0, "");
    read_all("R4 snap with event");
    cyc(15'h0003, 38'd7, 38'd0, 1'b0, 1'b0, 1'b0, '0, "");
    rd(9'h004, "R4 shadow holds");

    // R1 and R6: walk the receive-octet counter to the top and wrap it
    cyc('0, '0, '0, 1'b0, 1'b1, 1'b0, '0, "");
    for (int k = 0; k < 4; k++) cyc(15'h0001, BMAX, '0, 1'b0, 1'b0, 1'b0, '0, "");
    cyc('0, '0, '0, 1'b1, 1'b0, 1'b0, '0, "");
    rd(9'h004, "R1 low word"); chk("R1 low literal", got, 16'hFFFC);
    rd(9'h005, "R1 mid word"); chk("R1 mid literal", got, 16'hFFFF);
    rd(9'h006, "R1 high word"); chk("R1 high literal", got, 16'h00FF);
    cyc(15'h0001, 38'd4, '0, 1'b0, 1'b0, 1'b0, '0, "");
    rd(9'h105, "R8 other rollover word");
    // R7 wrap again in the same cycle as the read of word 0
    for (int k = 0; k < 4; k++) cyc(15'h0001, BMAX, '0, 1'b0, 1'b0, 1'b0, '0, "");
    cyc(15'h0001, 38'd4, '0, 1'b0, 1'b0, 1'b1, 9'h104, "R6 flag set");
    chk("R6 flag literal", got, 16'h0002);
    rd(9'h104, "R7 flag survives same-cycle read");
    chk("R7 flag literal", got, 16'h0002);
    rd(9'h104, "R7 cleared by read");
    chk("R7 cleared literal", got, 16'h0000);

    // R5 clear wins over snapshot and events
    for (int k = 0; k < 4; k++) cyc(15'h0001, BMAX, '0, 1'b0, 1'b0, 1'b0, '0, "");
    cyc(15'h0001, 38'd4, '0, 1'b0, 1'b0, 1'b0, '0, "");
    cyc(15'h7FFF, 38'd3, 38'd3, 1'b1, 1'b1, 1'b0, '0, "");
    rd(9'h104, "R5 flags cleared");
    cyc('0, '0, '0, 1'b1, 1'b0, 1'b0, '0, "");
    read_all("R5 counters cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule